// File: doc/BRIEF.md
# Per-Line Clock Edge Selector for an SD Card Slave Interface

This block sits between the pads of an SD-style slave interface and its protocol logic. It handles five lines: the command line and four data lines. For each line it decides which edge of the bus clock samples the incoming level. Separately, it decides which edge launches the outgoing level and its output enable. Board traces add delay, so a line whose data changes near one edge must be sampled or driven on the other edge.

Every input line is captured on both the rising and the falling edge, and the copy taken on the chosen edge is handed on. Every output and its enable are registered on both edges, and the copy for the chosen edge goes to the pad. Each line resolves its own edges independently.

The sampling edge is chosen in this order:
- a force-rising mask;
- then a force-falling mask;
- then a sampling strap.

The driving edge is chosen in this order:
- a force-falling mask;
- then a force-rising mask;
- then a high-speed qualification that needs three enables at once;
- then a driving strap.

Both straps are latched while reset is held.

Top module: `sdio_edge_sel`

## Requirements
- R1: Bit 0 of every line-indexed port and mask is the command line, and bits 1 to 4 are data lines 0 to 3. Each line's edges depend only on that line's mask bits, the shared high-speed enables and the straps.
- R2: When a line's `samp_force_rise` bit is 1, that line samples on the rising edge whatever else is set.
- R3: When a line's `samp_force_rise` bit is 0 and its `samp_force_fall` bit is 1, that line samples on the falling edge.
- R4: When both sampling force bits of a line are 0, the latched sampling strap picks the edge: 1 means falling, 0 means rising.
- R5: When a line's `drv_force_fall` bit is 1, that line's output and enable are launched on the falling edge whatever else is set.
- R6: When a line's `drv_force_fall` bit is 0 and its `drv_force_rise` bit is 1, the line launches on the rising edge.
- R7: When both driving force bits of a line are 0 and `hs_local_en`, `hs_ctrl_en` and `hs_host_flag` are all 1, the line launches on the rising edge. If any of the three is 0, this rule does not apply.
- R8: When no higher driving rule applies, the latched driving strap picks the edge: 1 means falling, 0 means rising.
- R9: Both straps are captured on every rising edge while `rst` is 1. After `rst` falls they hold, and later changes on the strap pins have no effect until the next reset.
- R10: A line's `pad_oe` is launched on the same edge as its `pad_out`. Both show the `out_*_i` values captured on that edge.
- R11: `in_data` is registered on the rising edge. A rising-sampled line shows the level that was present at the rising edge one cycle before. A falling-sampled line shows the level at the falling edge just before the update.
- R12: While reset is held, `in_data`, `pad_out` and `pad_oe` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; both edges are used |
| rst | input | 1 | Synchronous active-high reset |
| strap_samp_fall | input | 1 | Sampling strap, 1 = falling edge; latched during reset |
| strap_drv_fall | input | 1 | Driving strap, 1 = falling edge; latched during reset |
| samp_force_rise | input | 5 | Per-line force to sample on the rising edge |
| samp_force_fall | input | 5 | Per-line force to sample on the falling edge |
| drv_force_fall | input | 5 | Per-line force to drive on the falling edge |
| drv_force_rise | input | 5 | Per-line force to drive on the rising edge |
| hs_local_en | input | 1 | Local high-speed enable |
| hs_ctrl_en | input | 1 | High-speed control enable |
| hs_host_flag | input | 1 | Host-written enable-high-speed flag |
| line_in | input | 5 | Levels arriving from the pads |
| in_data | output | 5 | Per-line value captured on the selected edge |
| out_data_i | input | 5 | Levels to be driven |
| out_en_i | input | 5 | Output enables to be driven |
| pad_out | output | 5 | Launched output levels |
| pad_oe | output | 5 | Launched output enables |

## Verification
For inputs, the bench places one level on a line across a falling edge and the opposite level across the next rising edge, then restores the first level. It reads `in_data` 2 ns after the second rising edge. At that moment a rising-sampled line must show the opposite level and a falling-sampled line the first one.

For outputs, the bench presents one value before a rising edge and its complement before the following falling edge. It reads `pad_out` and `pad_oe` 5 ns after that falling edge. A rising-launched line must still show the first value, and a falling-launched line must already show the complement.

Every combination of force masks, high-speed enables and strap values is swept in this way. The strap pins are flipped after each reset, so that only the latched values can explain the results.

// File: rtl/sdio_edge_pkg.sv
package sdio_edge_pkg;
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_t;

  localparam int unsigned DEF_LINES = 5;
endpackage

// File: rtl/sdio_strap_latch.sv
module sdio_strap_latch (
  input  logic clk,
  input  logic rst,
  input  logic strap_samp_i,
  input  logic strap_drv_i,
  output logic strap_samp_q,
  output logic strap_drv_q
);
  // Straps track their pins only while reset is held.
  always_ff @(posedge clk) begin
    if (rst) begin
      strap_samp_q <= strap_samp_i;
      strap_drv_q  <= strap_drv_i;
    end
  end
endmodule

// File: rtl/sdio_edge_resolve.sv
module sdio_edge_resolve
  import sdio_edge_pkg::*;
#(
  parameter int unsigned N_LINES = DEF_LINES
) (
  input  logic [N_LINES-1:0] samp_force_rise,
  input  logic [N_LINES-1:0] samp_force_fall,
  input  logic [N_LINES-1:0] drv_force_fall,
  input  logic [N_LINES-1:0] drv_force_rise,
  input  logic               hs_local_en,
  input  logic               hs_ctrl_en,
  input  logic               hs_host_flag,
  input  logic               strap_samp_fall,
  input  logic               strap_drv_fall,
  output logic [N_LINES-1:0] samp_fall,
  output logic [N_LINES-1:0] drv_fall
);
  logic hs_qualified;
  assign hs_qualified = hs_local_en & hs_ctrl_en & hs_host_flag;

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    edge_t samp_edge;
    edge_t drv_edge;

    always_comb begin
      if (samp_force_rise[g])      samp_edge = EDGE_RISE;
      else if (samp_force_fall[g]) samp_edge = EDGE_FALL;
      else                         samp_edge = strap_samp_fall ? EDGE_FALL : EDGE_RISE;
    end

    always_comb begin
      if (drv_force_fall[g])      drv_edge = EDGE_FALL;
      else if (drv_force_rise[g]) drv_edge = EDGE_RISE;
      else if (hs_qualified)      drv_edge = EDGE_RISE;
      else                        drv_edge = strap_drv_fall ? EDGE_FALL : EDGE_RISE;
    end

    assign samp_fall[g] = (samp_edge == EDGE_FALL);
    assign drv_fall[g]  = (drv_edge == EDGE_FALL);
  end
endmodule

// File: rtl/sdio_in_capture.sv
module sdio_in_capture #(
  parameter int unsigned N_LINES = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] line_in,
  input  logic [N_LINES-1:0] samp_fall,
  output logic [N_LINES-1:0] in_data
);
  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    logic rise_q;
    logic fall_q;
    logic sel_q;

    always_ff @(posedge clk) begin
      if (rst) rise_q <= 1'b0;
      else     rise_q <= line_in[g];
    end

    always_ff @(negedge clk) begin
      if (rst) fall_q <= 1'b0;
      else     fall_q <= line_in[g];
    end

    // Hand the chosen copy over into the rising-edge domain.
    always_ff @(posedge clk) begin
      if (rst) sel_q <= 1'b0;
      else     sel_q <= samp_fall[g] ? fall_q : rise_q;
    end

    assign in_data[g] = sel_q;
  end
endmodule

// File: rtl/sdio_out_launch.sv
module sdio_out_launch #(
  parameter int unsigned N_LINES = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] data_i,
  input  logic [N_LINES-1:0] oe_i,
  input  logic [N_LINES-1:0] drv_fall,
  output logic [N_LINES-1:0] pad_out,
  output logic [N_LINES-1:0] pad_oe
);
  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    logic d_rise_q, e_rise_q;
    logic d_fall_q, e_fall_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        d_rise_q <= 1'b0;
        e_rise_q <= 1'b0;
      end else begin
        d_rise_q <= data_i[g];
        e_rise_q <= oe_i[g];
      end
    end

    always_ff @(negedge clk) begin
      if (rst) begin
        d_fall_q <= 1'b0;
        e_fall_q <= 1'b0;
      end else begin
        d_fall_q <= data_i[g];
        e_fall_q <= oe_i[g];
      end
    end

    // Data and enable always take the same edge's pair.
    assign pad_out[g] = drv_fall[g] ? d_fall_q : d_rise_q;
    assign pad_oe[g]  = drv_fall[g] ? e_fall_q : e_rise_q;
  end
endmodule

// File: rtl/sdio_edge_sel.sv
module sdio_edge_sel
  import sdio_edge_pkg::*;
#(
  parameter int unsigned N_LINES = DEF_LINES
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               strap_samp_fall,
  input  logic               strap_drv_fall,
  input  logic [N_LINES-1:0] samp_force_rise,
  input  logic [N_LINES-1:0] samp_force_fall,
  input  logic [N_LINES-1:0] drv_force_fall,
  input  logic [N_LINES-1:0] drv_force_rise,
  input  logic               hs_local_en,
  input  logic               hs_ctrl_en,
  input  logic               hs_host_flag,
  input  logic [N_LINES-1:0] line_in,
  output logic [N_LINES-1:0] in_data,
  input  logic [N_LINES-1:0] out_data_i,
  input  logic [N_LINES-1:0] out_en_i,
  output logic [N_LINES-1:0] pad_out,
  output logic [N_LINES-1:0] pad_oe
);
  logic               strap_samp_q;
  logic               strap_drv_q;
  logic [N_LINES-1:0] samp_fall;
  logic [N_LINES-1:0] drv_fall;

  sdio_strap_latch u_strap (
    .clk          (clk),
    .rst          (rst),
    .strap_samp_i (strap_samp_fall),
    .strap_drv_i  (strap_drv_fall),
    .strap_samp_q (strap_samp_q),
    .strap_drv_q  (strap_drv_q)
  );

  sdio_edge_resolve #(.N_LINES(N_LINES)) u_resolve (
    .samp_force_rise (samp_force_rise),
    .samp_force_fall (samp_force_fall),
    .drv_force_fall  (drv_force_fall),
    .drv_force_rise  (drv_force_rise),
    .hs_local_en     (hs_local_en),
    .hs_ctrl_en      (hs_ctrl_en),
    .hs_host_flag    (hs_host_flag),
    .strap_samp_fall (strap_samp_q),
    .strap_drv_fall  (strap_drv_q),
    .samp_fall       (samp_fall),
    .drv_fall        (drv_fall)
  );

  sdio_in_capture #(.N_LINES(N_LINES)) u_incap (
    .clk       (clk),
    .rst       (rst),
    .line_in   (line_in),
    .samp_fall (samp_fall),
    .in_data   (in_data)
  );

  sdio_out_launch #(.N_LINES(N_LINES)) u_launch (
    .clk      (clk),
    .rst      (rst),
    .data_i   (out_data_i),
    .oe_i     (out_en_i),
    .drv_fall (drv_fall),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe)
  );
endmodule

// File: rtl/sdio_edge_sel_chk.sv
module sdio_edge_sel_chk #(
  parameter int unsigned N_LINES = 5
) (
  input logic               clk,
  input logic               rst,
  input logic [N_LINES-1:0] samp_force_rise,
  input logic [N_LINES-1:0] samp_force_fall,
  input logic [N_LINES-1:0] drv_force_fall,
  input logic [N_LINES-1:0] drv_force_rise,
  input logic               hs_local_en,
  input logic               hs_ctrl_en,
  input logic               hs_host_flag,
  input logic [N_LINES-1:0] line_in,
  input logic [N_LINES-1:0] in_data,
  input logic [N_LINES-1:0] out_data_i,
  input logic [N_LINES-1:0] out_en_i,
  input logic [N_LINES-1:0] pad_out,
  input logic [N_LINES-1:0] pad_oe
);
  logic [1:0] since_rst;
  logic       warm;

  always_ff @(posedge clk) begin
    if (rst)                  since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end
  assign warm = (since_rst >= 2'd2);

  logic [N_LINES-1:0] hs_rise_lines;
  assign hs_rise_lines = ~drv_force_fall & ~drv_force_rise
                         & {N_LINES{hs_local_en & hs_ctrl_en & hs_host_flag}};

  // R2
  samp_force_rise_chk: assert property (@(posedge clk) disable iff (rst || !warm)
    ((in_data ^ $past(line_in, 2)) & $past(samp_force_rise)) == '0);

  // R5
  drv_force_fall_chk: assert property (@(negedge clk) disable iff (rst || !warm)
    ((pad_out ^ $past(out_data_i)) & drv_force_fall) == '0);

  // R10
  oe_fall_pair_chk: assert property (@(negedge clk) disable iff (rst || !warm)
    ((pad_oe ^ $past(out_en_i)) & drv_force_fall) == '0);

  // R6
  drv_force_rise_chk: assert property (@(posedge clk) disable iff (rst || !warm)
    ((pad_out ^ $past(out_data_i)) & drv_force_rise & ~drv_force_fall) == '0);

  // R7
  hs_rise_chk: assert property (@(posedge clk) disable iff (rst || !warm)
    ((pad_out ^ $past(out_data_i)) & hs_rise_lines) == '0);
endmodule

bind sdio_edge_sel sdio_edge_sel_chk #(.N_LINES(N_LINES)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .samp_force_rise (samp_force_rise),
  .samp_force_fall (samp_force_fall),
  .drv_force_fall  (drv_force_fall),
  .drv_force_rise  (drv_force_rise),
  .hs_local_en     (hs_local_en),
  .hs_ctrl_en      (hs_ctrl_en),
  .hs_host_flag    (hs_host_flag),
  .line_in         (line_in),
  .in_data         (in_data),
  .out_data_i      (out_data_i),
  .out_en_i        (out_en_i),
  .pad_out         (pad_out),
  .pad_oe          (pad_oe)
);

// File: tb/sdio_edge_sel_bench.sv
`timescale 1ns/1ps
module sdio_edge_sel_bench;
  localparam int N = 5;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         strap_samp_fall = 1'b0, strap_drv_fall = 1'b0;
  logic [N-1:0] samp_force_rise = '0, samp_force_fall = '0;
  logic [N-1:0] drv_force_fall = '0, drv_force_rise = '0;
  logic         hs_local_en = 1'b0, hs_ctrl_en = 1'b0, hs_host_flag = 1'b0;
  logic [N-1:0] line_in = '0, out_data_i = '0, out_en_i = '0;
  logic [N-1:0] in_data, pad_out, pad_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  sdio_edge_sel #(.N_LINES(N)) u_sdio_edge_sel (
    .clk(clk), .rst(rst),
    .strap_samp_fall(strap_samp_fall), .strap_drv_fall(strap_drv_fall),
    .samp_force_rise(samp_force_rise), .samp_force_fall(samp_force_fall),
    .drv_force_fall(drv_force_fall), .drv_force_rise(drv_force_rise),
    .hs_local_en(hs_local_en), .hs_ctrl_en(hs_ctrl_en), .hs_host_flag(hs_host_flag),
    .line_in(line_in), .in_data(in_data),
    .out_data_i(out_data_i), .out_en_i(out_en_i),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Expected falling-edge selection per line, from the requirement text.
  function automatic logic [N-1:0] model_samp(input logic [N-1:0] fr, input logic [N-1:0] ff,
                                              input logic strap);
    logic [N-1:0] res;
    for (int i = 0; i < N; i++) begin
      if (fr[i])      res[i] = 1'b0;   // R2
      else if (ff[i]) res[i] = 1'b1;   // R3
      else            res[i] = strap;  // R4
    end
    return res;
  endfunction

  function automatic logic [N-1:0] model_drv(input logic [N-1:0] ff, input logic [N-1:0] fr,
                                             input logic [2:0] hs, input logic strap);
    logic [N-1:0] res;
    for (int i = 0; i < N; i++) begin
      if (ff[i])            res[i] = 1'b1;   // R5
      else if (fr[i])       res[i] = 1'b0;   // R6
      else if (hs == 3'b111) res[i] = 1'b0;  // R7
      else                  res[i] = strap;  // R8
    end
    return res;
  endfunction

  task automatic do_reset(input logic s_samp, input logic s_drv);
    @(posedge clk); #2;
    rst = 1'b1; strap_samp_fall = s_samp; strap_drv_fall = s_drv;
    repeat (3) @(posedge clk);
    #2;
    // R12: outputs cleared during reset
    chk("R12 in_data reset", in_data, '0);
    chk("R12 pad_out reset", pad_out, '0);
    chk("R12 pad_oe reset", pad_oe, '0);
    rst = 1'b0;
    // R9: flip strap pins after release; latched values must rule
    strap_samp_fall = ~s_samp; strap_drv_fall = ~s_drv;
  endtask

  task automatic samp_case(input logic [N-1:0] fr, input logic [N-1:0] ff, input logic strap);
    logic [N-1:0] pa, fsel;
    pa = {fr[2:0], ff[1:0]} ^ 5'b10110;
    fsel = model_samp(fr, ff, strap);
    @(posedge clk); #2;
    samp_force_rise = fr; samp_force_fall = ff; line_in = pa;
    @(negedge clk); #2 line_in = ~pa;
    @(posedge clk); #2 line_in = pa;
    @(posedge clk); #2;
    // R1 R2 R3 R4 R9 R11: falling lines hold pa, rising lines ~pa
    chk("R11 sample edge (R1 R2 R3 R4 R9)", in_data, (fsel & pa) | (~fsel & ~pa));
  endtask

  task automatic samp_sweep(input logic strap);
    for (int r = 0; r < 32; r++)
      for (int f = 0; f < 32; f++)
        samp_case(N'(r), N'(f), strap);
  endtask

  task automatic drv_case(input logic [N-1:0] ff, input logic [N-1:0] fr,
                          input logic [2:0] hs, input logic strap);
    logic [N-1:0] w, wo, fsel;
    w  = ff ^ {fr[1:0], hs};
    wo = ~(fr ^ 5'b01101);
    fsel = model_drv(ff, fr, hs, strap);
    @(posedge clk); #2;
    drv_force_fall = ff; drv_force_rise = fr;
    {hs_local_en, hs_ctrl_en, hs_host_flag} = hs;
    out_data_i = w; out_en_i = wo;
    @(posedge clk); #2 out_data_i = ~w; out_en_i = ~wo;
    @(negedge clk); #2 out_data_i = w; out_en_i = wo;
    #3;
    chk("R5 R6 R7 R8 R9 drive edge", pad_out, (fsel & ~w) | (~fsel & w));
    chk("R10 oe edge", pad_oe, (fsel & ~wo) | (~fsel & wo));
  endtask

  task automatic drv_sweep(input logic strap);
    for (int f = 0; f < 32; f++)
      for (int r = 0; r < 32; r++)
        for (int h = 0; h < 8; h++)
          drv_case(N'(f), N'(r), 3'(h), strap);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset(1'b1, 1'b1);
    samp_sweep(1'b1);
    drv_sweep(1'b1);
    do_reset(1'b0, 1'b0);
    samp_sweep(1'b0);
    drv_sweep(1'b0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule